// File: doc/BRIEF.md
# AFSK Tone Modulator with Framing

This block turns a stream of bytes into an 8-bit unsigned audio sample stream for a DAC running at a fixed sample rate. The bytes are sent as bits at 1200 bit/s. The bits are NRZI coded onto two tones: a 1 keeps the current tone and a 0 switches to the other tone. A transmission begins when a byte is offered while the block is idle. The block first sends a loadable number of opening flag bytes, then the payload, and then flag bytes until a loadable closing count runs out. After five ones in a row the block inserts a zero. Flag bytes and abort-pattern bytes that are not escaped are exempt from this stuffing. An escape byte is never sent itself; it makes the block send the byte that follows with stuffing enabled.

Each output sample comes from a 512-step phase accumulator. The accumulator reads a computed quarter-wave table and mirrors it to build the full wave. One sample is produced for each pulse of `sample_tick`. Bytes enter through a valid/ready port. `in_ready` is raised only in the single clock in which a byte boundary needs a payload byte, and a transfer happens when `in_valid` and `in_ready` are both high on a clock edge. If `in_valid` is low in that clock, the source counts as empty and the block falls back to closing flags, or stops. The source may hold a byte for as long as it likes. Its data must stay stable while `in_valid` is high and no transfer has taken place.

Top module: `afsk_modulator`

## Requirements
- R1: The 128-entry quarter table holds Q(i) = 128 + floor((2032·p + d/2) / d), where p = i·(256−i) and d = 327680 − 4·p. For a phase ph, let f = ph mod 256. The table index is f when f < 128 and 255−f otherwise. The output is Q(index) when ph < 256 and 255−Q(index) when ph ≥ 256.
- R2: The phase steps by round(512·1200/SAMPLE_RATE) on the mark tone (64 at 9600) and by round(512·2200/SAMPLE_RATE) on the space tone (117 at 9600), and wraps modulo 512. The phase is 0 when a transmission starts, and each sample shows the phase after its step.
- R3: The sample output changes only in response to `sample_tick`. Each tick gives one sample, and each bit lasts SAMPLE_RATE/1200 ticks.
- R4: Bits of each byte go out LSB first. A 1 keeps the tone, a 0 switches it, and every transmission starts on the mark tone.
- R5: When stuffing is enabled and five ones in a row have been sent, a 0 (a tone switch) is inserted before the next bit and the ones count restarts. Any sent 0 also restarts the count.
- R6: Payload bytes 0x7E (flag) and 0x7F (abort pattern) that are not escaped are sent with stuffing disabled, as are all opening and closing flags. The ones count restarts at the start of a byte that follows an unstuffed byte.
- R7: The escape byte 0x1B is consumed but not sent, and the next byte is sent with stuffing enabled, whatever its value. If no byte follows the escape, the transmission stops at once and no closing flags are sent.
- R8: `preamble_len` flag bytes (0x7E) are sent before any payload byte is taken.
- R9: When the source is empty at a byte boundary, flag bytes are sent while the closing count (loaded from `trailer_len`) is nonzero. When that count is zero, the transmission stops.
- R10: `busy` rises on the clock after `in_valid` is seen while idle. It falls on the tick that follows the last sample. While `busy` is low, `sample_out` is 128.
- R11: `in_ready` is never high while `busy` is low, and each payload byte offered is taken exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sample_tick | input | 1 | One-clock strobe asking for the next sample |
| in_valid | input | 1 | Payload byte offered |
| in_ready | output | 1 | Byte taken on this edge if valid |
| in_data | input | 8 | Payload byte |
| preamble_len | input | CNT_W | Opening flag count, loaded at start |
| trailer_len | input | CNT_W | Closing flag count, loaded at start |
| sample_out | output | 8 | Unsigned audio sample |
| busy | output | 1 | Transmission in progress |

## Verification
The assertions assume that `sample_tick` pulses are at least four clocks apart. This leaves room for the fetch, escape and emit steps between ticks. They also assume that `in_data` holds steady while it is offered. The bench sends a tick every seven clocks and drives the byte port from a queue, changing it only on falling edges. It raises `in_valid` whenever the queue holds data, so an empty source is seen exactly when the payload runs out. The reference model builds the stuffed bit list and the NRZI sample list from the requirements. It compares every sample, and it counts every byte taken against the payload length.

// File: rtl/afsk_pkg.sv
package afsk_pkg;
  localparam int PHASE_W = 9;
  localparam int QUARTER = 128;
  localparam int BIT_RATE = 1200;
  localparam int MARK_HZ = 1200;
  localparam int SPACE_HZ = 2200;
  localparam logic [7:0] FLAG_BYTE = 8'h7E;
  localparam logic [7:0] ABORT_BYTE = 8'h7F;
  localparam logic [7:0] ESC_BYTE = 8'h1B;
  localparam logic [7:0] MID_LEVEL = 8'd128;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_FETCH,
    ST_ESC,
    ST_EMIT
  } tx_state_t;

  function automatic int tone_step(int freq, int rate);
    return ((1 << PHASE_W) * freq + rate / 2) / rate;
  endfunction

  function automatic logic [7:0] quarter_sine(int i);
    int p;
    int d;
    p = i * (256 - i);
    d = 327680 - 4 * p;
    return 8'(128 + (2032 * p + d / 2) / d);
  endfunction
endpackage

// File: rtl/afsk_sine_rom.sv
module afsk_sine_rom
  import afsk_pkg::*;
(
  input  logic [PHASE_W-1:0] phase,
  output logic [7:0]         level
);
  localparam int IDX_W = $clog2(QUARTER);

  logic [7:0] tbl [QUARTER];

  for (genvar g = 0; g < QUARTER; g++) begin : g_tbl
    localparam logic [7:0] ENTRY = quarter_sine(g);
    assign tbl[g] = ENTRY;
  end

  logic [IDX_W-1:0] idx;
  logic [7:0]       q;

  always_comb begin
    idx = phase[IDX_W] ? ~phase[IDX_W-1:0] : phase[IDX_W-1:0];
    q = tbl[idx];
    level = phase[PHASE_W-1] ? ~q : q;
  end
endmodule

// File: rtl/afsk_dds.sv
module afsk_dds
  import afsk_pkg::*;
#(
  parameter int SAMPLE_RATE = 9600
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       park,
  input  logic       step,
  input  logic       flip,
  output logic [7:0] level_o,
  output logic       on_space_o
);
  localparam logic [PHASE_W-1:0] MARK_INC = PHASE_W'(tone_step(MARK_HZ, SAMPLE_RATE));
  localparam logic [PHASE_W-1:0] SPACE_INC = PHASE_W'(tone_step(SPACE_HZ, SAMPLE_RATE));

  logic [PHASE_W-1:0] phase;
  logic [PHASE_W-1:0] phase_n;
  logic               tone_n;
  logic [7:0]         rom_q;

  always_comb begin
    tone_n = on_space_o ^ flip;
    phase_n = phase + (tone_n ? SPACE_INC : MARK_INC);
  end

  afsk_sine_rom u_rom (
    .phase(phase_n),
    .level(rom_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      on_space_o <= 1'b0;
      level_o <= MID_LEVEL;
    end else if (restart) begin
      phase <= '0;
      on_space_o <= 1'b0;
      level_o <= MID_LEVEL;
    end else if (park) begin
      level_o <= MID_LEVEL;
    end else if (step) begin
      phase <= phase_n;
      on_space_o <= tone_n;
      level_o <= rom_q;
    end
  end
endmodule

// File: rtl/afsk_modulator.sv
module afsk_modulator
  import afsk_pkg::*;
#(
  parameter int SAMPLE_RATE = 9600,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_tick,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic [CNT_W-1:0] preamble_len,
  input  logic [CNT_W-1:0] trailer_len,
  output logic [7:0]       sample_out,
  output logic             busy
);
  localparam int SPB = SAMPLE_RATE / BIT_RATE;
  localparam int SC_W = $clog2(SPB + 1);

  tx_state_t        state;
  logic [CNT_W-1:0] pre_cnt;
  logic [CNT_W-1:0] trl_cnt;
  logic [7:0]       shreg;
  logic [3:0]       bits_left;
  logic [SC_W-1:0]  samp_cnt;
  logic [2:0]       ones;
  logic             stuff_en;

  logic new_bit;
  logic do_stuff;
  logic data_bit;
  logic flip;
  logic stop_now;
  logic restart;
  logic step;
  logic on_space;

  always_comb begin
    in_ready = ((state == ST_FETCH) && (pre_cnt == '0)) || (state == ST_ESC);
    new_bit = (samp_cnt == '0);
    do_stuff = new_bit && stuff_en && (ones >= 3'd5);
    data_bit = shreg[0];
    flip = new_bit && (do_stuff || !data_bit);
    stop_now = ((state == ST_FETCH) && (pre_cnt == '0) && !in_valid && (trl_cnt == '0))
            || ((state == ST_ESC) && !in_valid);
    restart = (state == ST_IDLE) && in_valid;
    step = (state == ST_EMIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      pre_cnt <= '0;
      trl_cnt <= '0;
      shreg <= '0;
      bits_left <= '0;
      samp_cnt <= '0;
      ones <= '0;
      stuff_en <= 1'b0;
      busy <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (in_valid) begin
            pre_cnt <= preamble_len;
            trl_cnt <= trailer_len;
            bits_left <= '0;
            samp_cnt <= '0;
            ones <= '0;
            stuff_en <= 1'b0;
            busy <= 1'b1;
            state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (sample_tick) begin
            state <= (new_bit && (bits_left == '0)) ? ST_FETCH : ST_EMIT;
          end
        end
        ST_FETCH: begin
          if (!stuff_en) ones <= '0;
          if (pre_cnt != '0) begin
            pre_cnt <= pre_cnt - 1'b1;
            shreg <= FLAG_BYTE;
            stuff_en <= 1'b0;
            bits_left <= 4'd8;
            state <= ST_EMIT;
          end else if (in_valid) begin
            if (in_data == ESC_BYTE) begin
              state <= ST_ESC;
            end else begin
              shreg <= in_data;
              stuff_en <= !((in_data == FLAG_BYTE) || (in_data == ABORT_BYTE));
              bits_left <= 4'd8;
              state <= ST_EMIT;
            end
          end else if (trl_cnt != '0) begin
            trl_cnt <= trl_cnt - 1'b1;
            shreg <= FLAG_BYTE;
            stuff_en <= 1'b0;
            bits_left <= 4'd8;
            state <= ST_EMIT;
          end else begin
            busy <= 1'b0;
            state <= ST_IDLE;
          end
        end
        ST_ESC: begin
          if (in_valid) begin
            shreg <= in_data;
            stuff_en <= 1'b1;
            bits_left <= 4'd8;
            state <= ST_EMIT;
          end else begin
            busy <= 1'b0;
            state <= ST_IDLE;
          end
        end
        ST_EMIT: begin
          if (new_bit) begin
            samp_cnt <= SC_W'(SPB - 1);
            if (do_stuff) begin
              ones <= '0;
            end else begin
              ones <= data_bit ? ((ones == 3'd7) ? ones : ones + 3'd1) : 3'd0;
              shreg <= {1'b0, shreg[7:1]};
              bits_left <= bits_left - 4'd1;
            end
          end else begin
            samp_cnt <= samp_cnt - 1'b1;
          end
          state <= ST_WAIT;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  afsk_dds #(
    .SAMPLE_RATE(SAMPLE_RATE)
  ) u_dds (
    .clk(clk),
    .rst_n(rst_n),
    .restart(restart),
    .park(stop_now),
    .step(step),
    .flip(flip),
    .level_o(sample_out),
    .on_space_o(on_space)
  );

  p_ready_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> busy);

  p_idle_mid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sample_out == MID_LEVEL));

  p_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(in_valid));

  p_ones_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_EMIT) && stuff_en) |-> (ones <= 3'd5));

  p_tone_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_EMIT) && (samp_cnt != '0)) |=> $stable(on_space));

  p_bit_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_cnt < SC_W'(SPB)));
endmodule

// File: tb/afsk_modulator_test.sv
module afsk_modulator_test;
  localparam int SR = 9600;
  localparam int SPB = SR / 1200;
  localparam int MARK_STEP = (512 * 1200 + SR / 2) / SR;
  localparam int SPACE_STEP = (512 * 2200 + SR / 2) / SR;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sample_tick = 1'b0;
  logic       in_valid;
  logic       in_ready;
  logic [7:0] in_data;
  logic [7:0] preamble_len = 8'd0;
  logic [7:0] trailer_len = 8'd0;
  logic [7:0] sample_out;
  logic       busy;

  int checks = 0;
  int failures = 0;
  int accepted = 0;
  int ready_idle_hits = 0;
  bit pop_pend = 1'b0;
  logic [7:0] txq[$];

  always #4 clk = ~clk;

  afsk_modulator #(.SAMPLE_RATE(SR), .CNT_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .preamble_len(preamble_len), .trailer_len(trailer_len),
    .sample_out(sample_out), .busy(busy)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    in_valid = 1'b0;
    in_data = 8'd0;
    forever begin
      @(negedge clk);
      if (pop_pend) begin
        void'(txq.pop_front());
        accepted++;
      end
      in_valid = (txq.size() > 0);
      in_data = (txq.size() > 0) ? txq[0] : 8'd0;
      #1;
      pop_pend = in_valid && in_ready;
      if (in_ready && !busy) ready_idle_hits++;
    end
  end

  function automatic int qsin(int i);
    int p;
    int d;
    p = i * (256 - i);
    d = 327680 - 4 * p;
    return 128 + (2032 * p + d / 2) / d;
  endfunction

  function automatic int level_of(int ph);
    int f;
    int v;
    f = ph % 256;
    v = qsin((f >= 128) ? 255 - f : f);
    return (ph >= 256) ? 255 - v : v;
  endfunction

  task automatic do_tick();
    @(negedge clk);
    sample_tick = 1'b1;
    @(negedge clk);
    sample_tick = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic run_frame(string tag, int pre, int trl, logic [7:0] pl[$]);
    int vals[$];
    bit sts[$];
    int bits[$];
    int exp_s[$];
    int ones;
    bit prev_st;
    int tone;
    int ph;
    int i;
    int acc0;
    i = 0;
    for (int k = 0; k < pre; k++) begin vals.push_back(8'h7E); sts.push_back(1'b0); end
    while (i < pl.size()) begin
      if (pl[i] == 8'h1B) begin
        if (i + 1 < pl.size()) begin
          vals.push_back(pl[i+1]); sts.push_back(1'b1); i += 2;
        end else begin
          i = -1;
          break;
        end
      end else begin
        vals.push_back(pl[i]);
        sts.push_back(!(pl[i] == 8'h7E || pl[i] == 8'h7F));
        i++;
      end
    end
    if (i != -1)
      for (int k = 0; k < trl; k++) begin vals.push_back(8'h7E); sts.push_back(1'b0); end
    ones = 0;
    prev_st = 1'b0;
    for (int b = 0; b < vals.size(); b++) begin
      if (!prev_st) ones = 0;
      for (int k = 0; k < 8; k++) begin
        int bv;
        if (sts[b] && ones >= 5) begin bits.push_back(0); ones = 0; end
        bv = (vals[b] >> k) & 1;
        bits.push_back(bv);
        ones = bv ? ones + 1 : 0;
      end
      prev_st = sts[b];
    end
    tone = 0;
    ph = 0;
    foreach (bits[b]) begin
      if (bits[b] == 0) tone = 1 - tone;
      for (int s = 0; s < SPB; s++) begin
        ph = (ph + (tone ? SPACE_STEP : MARK_STEP)) % 512;
        exp_s.push_back(level_of(ph));
      end
    end
    acc0 = accepted;
    @(negedge clk);
    #2;
    preamble_len = 8'(pre);
    trailer_len = 8'(trl);
    foreach (pl[k]) txq.push_back(pl[k]);
    repeat (3) @(negedge clk);
    chk({tag, " R10 busy after start"}, int'(busy), 1);
    foreach (exp_s[k]) begin
      do_tick();
      chk({tag, " sample"}, int'(sample_out), exp_s[k]);
    end
    do_tick();
    chk({tag, " R10 busy low at end"}, int'(busy), 0);
    chk({tag, " R10 idle level"}, int'(sample_out), 128);
    chk({tag, " R11 bytes taken"}, accepted - acc0, pl.size());
    chk({tag, " R11 queue drained"}, txq.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R10 reset busy", int'(busy), 0);
    chk("R10 reset level", int'(sample_out), 128);
    chk("R11 reset ready", int'(in_ready), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_frame("R1 R2 R3 R4 R5 R8 R9 base", 1, 1, '{8'h00, 8'hFF, 8'h5A});
    run_frame("R6 R7 flags and escapes", 0, 2, '{8'h7F, 8'h1B, 8'h7E, 8'hF8, 8'h1B, 8'h1B, 8'h41});
    run_frame("R5 R6 cross-byte stuffing", 0, 1, '{8'hF8, 8'h7E, 8'hF0, 8'h0F});
    run_frame("R7 R8 escape at tail", 2, 3, '{8'h55, 8'h1B});
    run_frame("R9 R10 R3 minimal", 0, 0, '{8'hAA});
    repeat (20) @(negedge clk);
    chk("R10 stays idle", int'(busy), 0);
    chk("R11 ready while idle", ready_idle_hits, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule